// File: doc/BRIEF.md
# Programmable Biphasic Pulse Sequencer

This block is the timing engine for one stimulation channel. A command decoder writes 16-bit parameter words into it. The words set the phase widths, the gap between the two phases, the rest between pulses, the number of pulses, the phase order, the current range and the amplitude. When the channel is enabled, the sequencer turns those words into a train of biphasic pulses. It raises an anode drive enable and a cathode drive enable in turn, and during each phase it presents the amplitude code for the current DAC.

All durations are counted in ticks of a stimulation time base. The tick is a one-cycle enable pulse that the block receives from outside, so a single register value covers different time resolutions depending on the tick rate. A channel can start on its own, or it can wait for a global synchronisation strobe so that many channels start their first phase on the same tick. The parameters in use are copied when a train is armed, so the decoder can stage the next set while a train is still running.

Top module: `stim_pulse_seq`

## Requirements
- R1: After a synchronous reset, `anode_en`, `cathode_en`, `amp_code`, `range_hi`, `busy` and `done` are all 0.
- R2: The write port uses this register map:
  - address 1 is the mode word: bit 0 waits for sync, bit 1 selects cathode leading, bit 2 selects the high range.
  - address 2 is the interpulse rest.
  - address 3 is the pulse count in bits [11:0].
  - address 4 is the anodic width.
  - address 5 is the interphase gap.
  - address 6 is the cathodic width.
  - address 7 is the DAC word: bit 8 switches the DAC on, bits [7:0] are the amplitude.

  Each timed interval lasts exactly its register value in ticks.
- R3: When mode bit 1 is 0, every pulse starts with the anodic phase. When it is 1, every pulse starts with the cathodic phase.
- R4: `anode_en` and `cathode_en` are never high in the same cycle.
- R5: A count N from 0x000 to 0xFFE delivers exactly N pulses, with no rest after the last one. After that, `done` is 1 and `busy` is 0 until the enable is removed. A count of 0 yields `done` with no pulse.
- R6: A count of 0xFFF repeats pulses without end while the enable stays high.
- R7: An interval of length 0 is skipped. If all four intervals are 0, the train goes straight to `done` without driving any enable.
- R8: During a phase, `amp_code` equals DAC bits [7:0] when DAC bit 8 is 1, and is 0 otherwise. Outside a phase, `amp_code` is 0. `range_hi` follows mode bit 2 of the armed parameter set.
- R9: Writes that land while a train is armed or running do not change that train. They apply from the next time the channel is enabled.
- R10: Dropping `run_en` returns the sequencer to idle one clock later. At that point `busy` is 0 and both enables are 0.
- R11: With mode bit 0 set, an armed train waits with no phase output until a tick arrives together with `gsync`. Its first phase is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | 3 | Parameter register address |
| cfg_wdata | input | 16 | Parameter write data |
| run_en | input | 1 | Channel enable; rising level arms a train |
| tick | input | 1 | Stimulation time-base enable, one cycle per count |
| gsync | input | 1 | Global start strobe shared by all channels |
| anode_en | output | 1 | Anodic phase drive enable |
| cathode_en | output | 1 | Cathodic phase drive enable |
| amp_code | output | 8 | Amplitude code for the current DAC |
| range_hi | output | 1 | High current range select |
| busy | output | 1 | Train armed or running |
| done | output | 1 | Finite train completed |

## Verification
The interval counter or the slot pointer can hold a wrong value. A wrong counter shows up as a phase or gap that is one or more ticks too long or too short. A wrong pointer shows up as the wrong drive enable, or as a missing phase. Either fault appears at the enable pins at the very next tick boundary.

The pulse tally has no direct port. When it drifts, the number of anode and cathode segments changes, or `done` rises early or late, and this is only visible when the train ends.

A stale armed parameter copy shows up in the first phase after a restart. A missed capture shows up as a train that reflects writes made during the previous run.

// File: rtl/stim_pkg.sv
`timescale 1ns/1ps
package stim_pkg;

    parameter int TW     = 16;   // timing register width, in ticks
    parameter int CW     = 12;   // pulse count width
    parameter int AW     = 8;    // amplitude code width
    parameter int ADDR_W = 3;

    localparam logic [CW-1:0] CNT_FOREVER = '1;

    localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_REST   = 3'd2;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_WANODE = 3'd4;
    localparam logic [ADDR_W-1:0] A_GAP    = 3'd5;
    localparam logic [ADDR_W-1:0] A_WCATH  = 3'd6;
    localparam logic [ADDR_W-1:0] A_DAC    = 3'd7;

    localparam int MODE_SYNC  = 0;
    localparam int MODE_ORDER = 1;
    localparam int MODE_RANGE = 2;
    localparam int DAC_ON_BIT = AW;

    typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN, S_DONE} seq_state_e;

    // Slots within one pulse, in time order.
    typedef enum logic [1:0] {
        P_LEAD  = 2'd0,
        P_GAP   = 2'd1,
        P_TRAIL = 2'd2,
        P_REST  = 2'd3
    } slot_e;

    localparam int SLOTS = 4;
    localparam int SCAN  = SLOTS + 1;   // steps needed to revisit every slot once

    typedef struct packed {
        logic          cath_first;
        logic [TW-1:0] w_anode;
        logic [TW-1:0] w_cath;
        logic [TW-1:0] gap;
        logic [TW-1:0] ipi;
        logic [CW-1:0] count;
    } stim_timing_t;

    typedef struct packed {
        logic          sync_wait;
        logic          range_hi;
        logic          dac_on;
        logic [AW-1:0] amp;
        stim_timing_t  tm;
    } stim_cfg_t;

    function automatic logic [TW-1:0] slot_len(stim_timing_t t, slot_e s);
        logic [TW-1:0] r;
        case (s)
            P_LEAD:  r = t.cath_first ? t.w_cath : t.w_anode;
            P_GAP:   r = t.gap;
            P_TRAIL: r = t.cath_first ? t.w_anode : t.w_cath;
            default: r = t.ipi;
        endcase
        return r;
    endfunction

    function automatic logic slot_is_anode(stim_timing_t t, slot_e s);
        return (s == P_LEAD && !t.cath_first) || (s == P_TRAIL && t.cath_first);
    endfunction

    function automatic logic slot_is_cathode(stim_timing_t t, slot_e s);
        return (s == P_LEAD && t.cath_first) || (s == P_TRAIL && !t.cath_first);
    endfunction

endpackage

// File: rtl/stim_cfg_regs.sv
`timescale 1ns/1ps
module stim_cfg_regs
    import stim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TW-1:0]     wr_data,
    input  logic              capture,
    output stim_cfg_t         act
);

    stim_cfg_t stg_q;
    stim_cfg_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
            act_q <= '0;
        end else begin
            if (capture) begin
                act_q <= stg_q;
            end
            if (wr_en) begin
                case (wr_addr)
                    A_MODE: begin
                        stg_q.sync_wait     <= wr_data[MODE_SYNC];
                        stg_q.tm.cath_first <= wr_data[MODE_ORDER];
                        stg_q.range_hi      <= wr_data[MODE_RANGE];
                    end
                    A_REST:   stg_q.tm.ipi     <= wr_data;
                    A_COUNT:  stg_q.tm.count   <= wr_data[CW-1:0];
                    A_WANODE: stg_q.tm.w_anode <= wr_data;
                    A_GAP:    stg_q.tm.gap     <= wr_data;
                    A_WCATH:  stg_q.tm.w_cath  <= wr_data;
                    A_DAC: begin
                        stg_q.dac_on <= wr_data[DAC_ON_BIT];
                        stg_q.amp    <= wr_data[AW-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign act = act_q;

    // R9: the armed copy only moves on a capture
    a_r9_armed_frozen: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(act_q));

endmodule

// File: rtl/stim_advance.sv
`timescale 1ns/1ps
module stim_advance
    import stim_pkg::*;
(
    input  stim_timing_t  tm,
    input  slot_e         from_pos,
    input  logic [CW-1:0] from_np,
    output slot_e         to_pos,
    output logic [CW-1:0] to_np,
    output logic          finish
);

    logic          cont;
    slot_e         p_w;
    logic [CW-1:0] n_w;
    logic          hit_w;
    logic          fin_w;

    assign cont = (tm.count == CNT_FOREVER);

    // Walk forward from the slot just completed to the next slot of
    // nonzero length, counting pulse boundaries on the way.
    always_comb begin
        p_w   = from_pos;
        n_w   = from_np;
        hit_w = 1'b0;
        fin_w = 1'b0;
        for (int k = 0; k < SCAN; k++) begin
            if (!hit_w && !fin_w) begin
                if (p_w == P_REST) begin
                    n_w = n_w + 1'b1;
                    if (!cont && n_w == tm.count) begin
                        fin_w = 1'b1;
                    end else begin
                        p_w = P_LEAD;
                    end
                end else if (p_w == P_TRAIL && !cont && (n_w + 1'b1) == tm.count) begin
                    n_w   = n_w + 1'b1;
                    fin_w = 1'b1;
                end else begin
                    p_w = slot_e'(p_w + 2'd1);
                end
                if (!fin_w && slot_len(tm, p_w) != '0) begin
                    hit_w = 1'b1;
                end
            end
        end
        to_pos = p_w;
        to_np  = n_w;
        finish = fin_w | !hit_w;
    end

endmodule

// File: rtl/stim_seq_fsm.sv
`timescale 1ns/1ps
module stim_seq_fsm
    import stim_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         tick,
    input  logic         gsync,
    input  logic         sync_wait,
    input  stim_timing_t tm,
    output logic         capture,
    output seq_state_e   st,
    output slot_e        pos
);

    seq_state_e    st_q;
    slot_e         pos_q;
    logic [TW-1:0] cnt_q;
    logic [CW-1:0] np_q;

    slot_e         from_pos;
    logic [CW-1:0] from_np;
    slot_e         adv_pos;
    logic [CW-1:0] adv_np;
    logic          adv_fin;
    logic          go;
    logic [TW-1:0] cur_len;

    // Arming behaves as if a rest slot just ended before pulse zero.
    assign from_pos = (st_q == S_RUN) ? pos_q : P_REST;
    assign from_np  = (st_q == S_RUN) ? np_q  : '1;

    stim_advance u_adv (
        .tm       (tm),
        .from_pos (from_pos),
        .from_np  (from_np),
        .to_pos   (adv_pos),
        .to_np    (adv_np),
        .finish   (adv_fin)
    );

    assign go      = tick && (!sync_wait || gsync);
    assign cur_len = slot_len(tm, pos_q);
    assign capture = (st_q == S_IDLE) && run_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            pos_q <= P_LEAD;
            cnt_q <= '0;
            np_q  <= '0;
        end else if (!run_en) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: st_q <= S_ARM;
                S_ARM: begin
                    if (go) begin
                        if (adv_fin) begin
                            st_q <= S_DONE;
                        end else begin
                            st_q  <= S_RUN;
                            pos_q <= adv_pos;
                            np_q  <= adv_np;
                            cnt_q <= '0;
                        end
                    end
                end
                S_RUN: begin
                    if (tick) begin
                        if (cnt_q == cur_len - 1'b1) begin
                            cnt_q <= '0;
                            if (adv_fin) begin
                                st_q <= S_DONE;
                            end else begin
                                pos_q <= adv_pos;
                                np_q  <= adv_np;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign st  = st_q;
    assign pos = pos_q;

    // R10: a dropped enable is honoured on the next clock
    a_r10_drop_to_idle: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> st_q == S_IDLE);

    // R7: an occupied slot always has nonzero length and the count stays inside it
    a_r7_slot_in_range: assert property (@(posedge clk) disable iff (rst)
        st_q == S_RUN |-> cnt_q < cur_len);

    // R5: a finite train never works on a pulse index at or past its count
    a_r5_pulse_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_RUN && tm.count != CNT_FOREVER) |-> np_q < tm.count);

endmodule

// File: rtl/stim_pulse_seq.sv
`timescale 1ns/1ps
module stim_pulse_seq
    import stim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [TW-1:0]     cfg_wdata,
    input  logic              run_en,
    input  logic              tick,
    input  logic              gsync,
    output logic              anode_en,
    output logic              cathode_en,
    output logic [AW-1:0]     amp_code,
    output logic              range_hi,
    output logic              busy,
    output logic              done
);

    stim_cfg_t  act;
    logic       capture;
    seq_state_e st;
    slot_e      pos;
    logic       in_run;

    stim_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .capture (capture),
        .act     (act)
    );

    stim_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .tick      (tick),
        .gsync     (gsync),
        .sync_wait (act.sync_wait),
        .tm        (act.tm),
        .capture   (capture),
        .st        (st),
        .pos       (pos)
    );

    assign in_run     = (st == S_RUN);
    assign anode_en   = in_run && slot_is_anode(act.tm, pos);
    assign cathode_en = in_run && slot_is_cathode(act.tm, pos);
    assign amp_code   = ((anode_en || cathode_en) && act.dac_on) ? act.amp : '0;
    assign range_hi   = act.range_hi;
    assign busy       = (st == S_ARM) || in_run;
    assign done       = (st == S_DONE);

    // R4: the two drive enables are mutually exclusive
    a_r4_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(anode_en && cathode_en));

    // R5: a finished train drives nothing and is no longer busy
    a_r5_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!anode_en && !cathode_en && amp_code == '0 && !busy));

endmodule

// File: tb/stim_pulse_seq_bench.sv
`timescale 1ns/1ps
module stim_pulse_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        run_en = 1'b0;
    logic        tick = 1'b0;
    logic        gsync = 1'b0;
    logic        anode_en, cathode_en, range_hi, busy, done;
    logic [7:0]  amp_code;

    int nchk = 0;
    int nfail = 0;
    int tdiv = 0;

    // monitor state
    int seg_k [0:127];
    int seg_l [0:127];
    int nseg = 0;
    int exp_k [0:127];
    int exp_l [0:127];
    int nexp = 0;
    int amp_exp = 0;
    bit amp_bad = 0;
    bit ovl_bad = 0;
    int cls_v;

    stim_pulse_seq u_stim_pulse_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .run_en     (run_en),
        .tick       (tick),
        .gsync      (gsync),
        .anode_en   (anode_en),
        .cathode_en (cathode_en),
        .amp_code   (amp_code),
        .range_hi   (range_hi),
        .busy       (busy),
        .done       (done)
    );

    always #4 clk = ~clk;

    // time base: one tick every fourth clock
    always begin
        @(posedge clk);
        #1;
        tick = (tdiv == 0);
        tdiv = (tdiv + 1) % 4;
    end

    // run-length record of the drive pattern, one sample per tick
    always @(negedge clk) begin
        cls_v = anode_en ? 1 : (cathode_en ? 2 : 0);
        if (anode_en && cathode_en) ovl_bad = 1;
        if ((anode_en || cathode_en) && amp_code != amp_exp[7:0]) amp_bad = 1;
        if (!(anode_en || cathode_en) && amp_code != 8'd0) amp_bad = 1;
        if (tick && (busy || cls_v != 0)) begin
            if (nseg > 0 && seg_k[nseg-1] == cls_v) begin
                seg_l[nseg-1]++;
            end else if (!(nseg == 0 && cls_v == 0) && nseg < 128) begin
                seg_k[nseg] = cls_v;
                seg_l[nseg] = 1;
                nseg++;
            end
        end
    end

    task automatic summary_and_end();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary_and_end();
    end

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic setup(int mode, int wa, int wc, int g, int ip, int cnt, int dacw);
        wr(3'd1, 16'(mode));
        wr(3'd4, 16'(wa));
        wr(3'd6, 16'(wc));
        wr(3'd5, 16'(g));
        wr(3'd2, 16'(ip));
        wr(3'd3, 16'(cnt));
        wr(3'd7, 16'(dacw));
    endtask

    task automatic mon_clear();
        nseg = 0; amp_bad = 0; ovl_bad = 0;
    endtask

    task automatic start();
        mon_clear();
        @(posedge clk); #2;
        run_en = 1'b1;
    endtask

    task automatic stop();
        @(posedge clk); #2;
        run_en = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic wait_done(int limit, output bit ok);
        ok = 0;
        for (int i = 0; i < limit && !ok; i++) begin
            @(negedge clk);
            if (done) ok = 1;
        end
    endtask

    task automatic eadd(int k, int l);
        if (l == 0) return;
        if (nexp > 0 && exp_k[nexp-1] == k) exp_l[nexp-1] += l;
        else if (!(nexp == 0 && k == 0) && nexp < 128) begin
            exp_k[nexp] = k; exp_l[nexp] = l; nexp++;
        end
    endtask

    task automatic build(int wa, int wc, int g, int ip, int cnt, bit cf);
        nexp = 0;
        for (int p = 0; p < cnt; p++) begin
            eadd(cf ? 2 : 1, cf ? wc : wa);
            eadd(0, g);
            eadd(cf ? 1 : 2, cf ? wa : wc);
            if (p != cnt - 1) eadd(0, ip);
        end
    endtask

    task automatic cmp_segs(string req, int upto);
        bit ok;
        int bad;
        int lim;
        ok = 1; bad = -1;
        lim = (upto < 0) ? nexp : upto;
        if (upto < 0 && nseg != nexp) ok = 0;
        if (upto >= 0 && nseg < upto) ok = 0;
        for (int i = 0; i < lim && i < 128; i++) begin
            if (ok && (seg_k[i] != exp_k[i] || seg_l[i] != exp_l[i])) begin
                ok = 0; bad = i;
            end
        end
        nchk++;
        if (!ok) begin
            nfail++;
            if (bad < 0)
                $display("FAIL %s segment count actual=%0d expected=%0d", req, nseg, lim);
            else
                $display("FAIL %s segment %0d kind/len actual=%0d/%0d expected=%0d/%0d",
                         req, bad, seg_k[bad], seg_l[bad], exp_k[bad], exp_l[bad]);
        end
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        chk(anode_en == 0, "R1", "anode_en after reset", anode_en, 0);
        chk(cathode_en == 0, "R1", "cathode_en after reset", cathode_en, 0);
        chk(amp_code == 0, "R1", "amp_code after reset", amp_code, 0);
        chk(range_hi == 0, "R1", "range_hi after reset", range_hi, 0);
        chk(busy == 0 && done == 0, "R1", "busy|done after reset", busy | done, 0);
    endtask

    // R2 R4 R5 R8: anode-leading finite train
    task automatic t_anode_lead();
        bit ok;
        setup(0, 3, 2, 2, 4, 3, 16'h015A);
        amp_exp = 8'h5A;
        start();
        wait_done(3000, ok);
        chk(ok, "R5", "done after three pulses", ok, 1);
        build(3, 2, 2, 4, 3, 0);
        cmp_segs("R2", -1);
        chk(!amp_bad, "R8", "amplitude during phases", amp_bad, 0);
        chk(!ovl_bad, "R4", "enables overlapped", ovl_bad, 0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(done == 1 && busy == 0, "R5", "done held while enabled", done, 1);
        stop();
    endtask

    // R3 R8: cathode leading, high range
    task automatic t_cathode_lead();
        bit ok;
        setup(6, 4, 3, 1, 2, 2, 16'h01C3);
        amp_exp = 8'hC3;
        start();
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(range_hi == 1, "R8", "range_hi from mode bit 2", range_hi, 1);
        wait_done(3000, ok);
        chk(ok, "R5", "done after two pulses", ok, 1);
        build(4, 3, 1, 2, 2, 1);
        cmp_segs("R3", -1);
        chk(nseg > 0 && seg_k[0] == 2, "R3", "first phase kind", nseg > 0 ? seg_k[0] : -1, 2);
        chk(!amp_bad, "R8", "amplitude cathode-first", amp_bad, 0);
        stop();
    endtask

    // R7: zero-length intervals skipped
    task automatic t_zero_slots();
        bit ok;
        setup(0, 0, 2, 2, 3, 3, 16'h0111);
        amp_exp = 8'h11;
        start();
        wait_done(3000, ok);
        chk(ok, "R7", "done with zero anodic width", ok, 1);
        build(0, 2, 2, 3, 3, 0);
        cmp_segs("R7", -1);
        stop();
        setup(0, 3, 2, 0, 0, 2, 16'h0111);
        start();
        wait_done(3000, ok);
        chk(ok, "R7", "done with zero gap and rest", ok, 1);
        build(3, 2, 0, 0, 2, 0);
        cmp_segs("R7", -1);
        stop();
        setup(0, 0, 0, 0, 0, 5, 16'h0111);
        start();
        wait_done(200, ok);
        chk(ok, "R7", "all-zero train reaches done", ok, 1);
        chk(nseg == 0, "R7", "segments on all-zero train", nseg, 0);
        stop();
    endtask

    // R5: count zero
    task automatic t_count_zero();
        bit ok;
        setup(0, 3, 3, 1, 1, 0, 16'h0120);
        amp_exp = 8'h20;
        start();
        wait_done(200, ok);
        chk(ok, "R5", "count 0 reaches done", ok, 1);
        chk(nseg == 0, "R5", "segments for count 0", nseg, 0);
        stop();
    endtask

    // R8: DAC switched off
    task automatic t_dac_off();
        bit ok;
        setup(0, 2, 2, 1, 1, 2, 16'h0077);
        amp_exp = 0;
        start();
        wait_done(2000, ok);
        build(2, 2, 1, 1, 2, 0);
        cmp_segs("R8", -1);
        chk(!amp_bad, "R8", "amp_code zero with DAC off", amp_bad, 0);
        stop();
    endtask

    // R6 R10: continuous train then disable mid-phase
    task automatic t_continuous();
        setup(0, 2, 2, 1, 3, 16'h0FFF, 16'h0133);
        amp_exp = 8'h33;
        start();
        repeat (700) @(posedge clk);
        build(2, 2, 1, 3, 10, 0);
        cmp_segs("R6", 16);
        @(negedge clk);
        chk(busy == 1 && done == 0, "R6", "still running", busy, 1);
        do @(negedge clk); while (!anode_en);
        @(posedge clk); #2;
        run_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(busy == 0, "R10", "busy one clock after disable", busy, 0);
        chk(anode_en == 0 && cathode_en == 0 && amp_code == 0, "R10",
            "drive one clock after disable", anode_en | cathode_en, 0);
        repeat (2) @(posedge clk);
    endtask

    // R9: writes during a run apply to the next train only
    task automatic t_snapshot();
        bit ok;
        setup(0, 3, 2, 1, 2, 2, 16'h0144);
        amp_exp = 8'h44;
        start();
        repeat (12) @(posedge clk);
        wr(3'd4, 16'd5);
        wr(3'd3, 16'd1);
        wr(3'd7, 16'h0155);
        wait_done(3000, ok);
        build(3, 2, 1, 2, 2, 0);
        cmp_segs("R9", -1);
        chk(!amp_bad, "R9", "old amplitude kept", amp_bad, 0);
        stop();
        amp_exp = 8'h55;
        start();
        wait_done(3000, ok);
        build(5, 2, 1, 2, 1, 0);
        cmp_segs("R9", -1);
        chk(!amp_bad, "R9", "new amplitude after restart", amp_bad, 0);
        stop();
    endtask

    // R11: wait for global sync
    task automatic t_sync();
        bit ok;
        setup(1, 2, 2, 1, 1, 2, 16'h0166);
        amp_exp = 8'h66;
        start();
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(busy == 1 && nseg == 0, "R11", "held before sync", nseg, 0);
        do begin @(posedge clk); #2; end while (!tick);
        gsync = 1'b1;
        @(posedge clk); #2;
        gsync = 1'b0;
        @(negedge clk);
        chk(anode_en == 1, "R11", "first phase after sync tick", anode_en, 1);
        wait_done(2000, ok);
        build(2, 2, 1, 1, 2, 0);
        cmp_segs("R11", -1);
        stop();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        rst = 1'b0;
        t_reset();
        t_anode_lead();
        t_cathode_lead();
        t_zero_slots();
        t_count_zero();
        t_dac_off();
        t_continuous();
        t_snapshot();
        t_sync();
        summary_and_end();
    end

endmodule